// File: doc/BRIEF.md
# Signed-Digit Capacitor Phase Sequencer

This block drives the switch network of a step-down switched-capacitor converter whose no-load ratio is a fraction k/2^n. The ratio can be written in several ways with a leading digit of 0 or 1 and fractional digits of -1, 0 or +1. The block finds every such signed-digit code for the requested numerator and stores them. It then steps through the stored codes in a fixed, repeating order, one code per switching tick. Cycling through all of these equivalent codes charges and discharges every flying capacitor, so the capacitor voltages settle at their binary-weighted values without a separate balancing loop.

Each applied code is turned into switch-group commands. The leading digit enables the input source in charging polarity. Each fractional digit j places flying capacitor j (weight 2^-j) in series with the output in one of two polarities, or leaves it out. A pulse on the start input loads the numerator and builds the code list. If the numerator changes later, the new value is only taken up when a full pass through the current list ends.

Top module: `scs_phase_seq`

## Requirements
- R1: While `active_o` is high, every code on `code_o` has the value A0·2^n + Σ Aj·2^(n-j) equal to the numerator the list was built for.
- R2: The list holds every valid code of that value once and only once, in ascending order of the unsigned `code_o` word. Each digit is 2-bit two's complement (-1 = 11, 0 = 00, +1 = 01). A0 is the most significant digit pair, and Aj sits at bits [2(n-j)+1 : 2(n-j)].
- R3: A start pulse sampled at a clock edge makes `active_o` rise 4^(n+1) edges later, with the first (lowest) code of the list on `code_o`.
- R4: Each tick sampled while active advances to the next stored code at that edge, and the last code wraps to the first. Without a tick the code holds.
- R5: `src_en_o` is 1 exactly when the applied A0 is 1.
- R6: Capacitor j takes `cap_cmd_o[2j-1:2j-2]` = 00 (disconnected) for digit 0, 01 (series, same polarity) for digit -1, and 10 (series, opposite polarity) for digit +1.
- R7: For an odd numerator the list has at least n+1 codes, and every capacitor that gets +1 in one code gets -1 in another code.
- R8: A changed numerator is applied only at the tick that leaves the last code. At that point the block rebuilds and drives all outputs to zero for 4^(n+1) edges, then starts the new list at its first code. With an unchanged numerator the list wraps with no gap.
- R9: After reset all outputs are zero. Ticks are ignored before start, and start is ignored while the block is active.
- R10: Numerator 0 gives a list with the single all-zero code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| num_i | input | NFRAC | Ratio numerator k (ratio k/2^NFRAC) |
| start_i | input | 1 | Load numerator and build the code list |
| tick_i | input | 1 | One-cycle switching-period strobe |
| active_o | output | 1 | A code is being applied |
| code_o | output | 2*(NFRAC+1) | Applied signed-digit code, zero when inactive |
| src_en_o | output | 1 | Input source connected in charging polarity |
| cap_cmd_o | output | 2*NFRAC | Per-capacitor connection command |

## Verification
The list build takes exactly 256 edges at the default resolution. This holds both after the start edge and after the tick that ends a cycle with a changed numerator. The bench counts 255 edges, checks that outputs are still zero, and then expects the first code one edge later. A code advance is due at the very edge that samples the tick. The bench therefore drives stimulus just after a rising edge and pushes each expected code into the scoreboard queue. A monitor pops that entry at the following falling edge and compares the code, its value, the source enable and every capacitor command.

// File: rtl/scs_pkg.sv
package scs_pkg;

   // capacitor connection command
   typedef enum logic [1:0] {
      CAP_OFF  = 2'b00,
      CAP_SAME = 2'b01,
      CAP_OPP  = 2'b10
   } cap_cmd_e;

   // digit encodings (2-bit two's complement)
   localparam logic [1:0] DIG_ZERO = 2'b00;
   localparam logic [1:0] DIG_POS  = 2'b01;
   localparam logic [1:0] DIG_BAD  = 2'b10;
   localparam logic [1:0] DIG_NEG  = 2'b11;

   // value of a packed code scaled by 2^n; -1000 marks an illegal word
   function automatic int code_value(logic [31:0] w, int n);
      int acc;
      logic [1:0] d;
      acc = 0;
      for (int i = 0; i <= n; i++) begin
         d = w[2*i +: 2];
         if (d == DIG_BAD) return -1000;
         if (i == n && d == DIG_NEG) return -1000;
         if (d == DIG_POS) acc = acc + (1 << i);
         if (d == DIG_NEG) acc = acc - (1 << i);
      end
      return acc;
   endfunction

   // largest number of codes any numerator can have at resolution n
   function automatic int max_codes(int n);
      int best;
      int cnt;
      best = 0;
      for (int k = 0; k < (1 << n); k++) begin
         cnt = 0;
         for (int w = 0; w < (1 << (2*(n+1))); w++)
            if (code_value(32'(w), n) == k) cnt++;
         if (cnt > best) best = cnt;
      end
      return best;
   endfunction

endpackage

// File: rtl/scs_code_enum.sv
module scs_code_enum #(
   parameter int NFRAC = 3
) (
   input  logic [2*(NFRAC+1)-1:0] cand_i,
   input  logic [NFRAC-1:0]       target_i,
   output logic                   match_o
);
   import scs_pkg::*;

   localparam int VW = NFRAC + 3;

   logic signed [VW-1:0] term [NFRAC+1];
   logic [NFRAC:0]       legal;
   logic signed [VW-1:0] sum;
   logic signed [VW-1:0] tgt;

   for (genvar g = 0; g <= NFRAC; g++) begin : g_digit
      localparam int WT = 1 << g;
      logic [1:0] d;
      assign d = cand_i[2*g +: 2];
      assign term[g] = (d == DIG_POS) ? VW'(WT) :
                       (d == DIG_NEG) ? -(VW'(WT)) : '0;
      if (g == NFRAC) begin : g_lead
         // leading digit may only be 0 or 1
         assign legal[g] = (d == DIG_ZERO) || (d == DIG_POS);
      end else begin : g_frac
         assign legal[g] = (d != DIG_BAD);
      end
   end

   always_comb begin
      sum = '0;
      for (int i = 0; i <= NFRAC; i++) sum = sum + term[i];
   end

   assign tgt     = $signed({{(VW-NFRAC){1'b0}}, target_i});
   assign match_o = (&legal) && (sum == tgt);

endmodule

// File: rtl/scs_code_store.sv
module scs_code_store #(
   parameter int W     = 8,
   parameter int DEPTH = 8
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       clr_i,
   input  logic                       push_i,
   input  logic [W-1:0]               push_word_i,
   input  logic [$clog2(DEPTH)-1:0]   rd_idx_i,
   output logic [W-1:0]               rd_word_o,
   output logic [$clog2(DEPTH+1)-1:0] count_o
);
   localparam int IW   = $clog2(DEPTH);
   localparam int CNTW = $clog2(DEPTH + 1);
   localparam logic [CNTW-1:0] DEPTH_C = CNTW'(DEPTH);

   logic [W-1:0]    mem [DEPTH];
   logic [CNTW-1:0] count;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         count <= '0;
      end else if (clr_i) begin
         count <= '0;
      end else if (push_i && count < DEPTH_C) begin
         count <= count + CNTW'(1);
      end
   end

   always_ff @(posedge clk_i) begin
      if (!clr_i && push_i && count < DEPTH_C) mem[count[IW-1:0]] <= push_word_i;
   end

   assign rd_word_o = mem[rd_idx_i];
   assign count_o   = count;

   // R2
   room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push_i && !clr_i) |-> (count < DEPTH_C));

   // R2
   ascending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push_i && !clr_i && count != '0 && count < DEPTH_C)
         |-> (push_word_i > mem[IW'(count - CNTW'(1))]));

endmodule

// File: rtl/scs_cap_decode.sv
module scs_cap_decode #(
   parameter int NFRAC = 3
) (
   input  logic [2*(NFRAC+1)-1:0] code_i,
   output logic                   src_en_o,
   output logic [2*NFRAC-1:0]     cap_cmd_o
);
   import scs_pkg::*;

   localparam int CW = 2 * (NFRAC + 1);

   assign src_en_o = (code_i[CW-2 +: 2] == DIG_POS);

   for (genvar j = 1; j <= NFRAC; j++) begin : g_cap
      logic [1:0] d;
      cap_cmd_e   cmd;
      assign d = code_i[2*(NFRAC-j) +: 2];
      always_comb begin
         case (d)
            DIG_NEG: cmd = CAP_SAME;
            DIG_POS: cmd = CAP_OPP;
            default: cmd = CAP_OFF;
         endcase
      end
      assign cap_cmd_o[2*(j-1) +: 2] = cmd;
   end

endmodule

// File: rtl/scs_phase_seq.sv
module scs_phase_seq #(
   parameter int NFRAC      = 3,
   parameter int LIST_DEPTH = 8
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic [NFRAC-1:0]        num_i,
   input  logic                    start_i,
   input  logic                    tick_i,
   output logic                    active_o,
   output logic [2*(NFRAC+1)-1:0]  code_o,
   output logic                    src_en_o,
   output logic [2*NFRAC-1:0]      cap_cmd_o
);
   localparam int CW   = 2 * (NFRAC + 1);
   localparam int IW   = $clog2(LIST_DEPTH);
   localparam int CNTW = $clog2(LIST_DEPTH + 1);
   localparam logic [CW-1:0] CAND_LAST = {CW{1'b1}};

   if (NFRAC < 1 || NFRAC > 4) begin : g_bad_nfrac
      $error("NFRAC must lie in 1..4");
   end
   if (LIST_DEPTH < 2 || LIST_DEPTH < scs_pkg::max_codes(NFRAC)) begin : g_bad_depth
      $error("LIST_DEPTH too small for the code count at this resolution");
   end

   typedef enum logic [1:0] {ST_IDLE, ST_BUILD, ST_RUN} seq_state_e;

   seq_state_e       state;
   logic [CW-1:0]    cand;
   logic [IW-1:0]    idx;
   logic [NFRAC-1:0] cur_num;

   logic             match;
   logic             store_clr;
   logic             store_push;
   logic [CW-1:0]    rd_word;
   logic [CNTW-1:0]  count;
   logic             at_last;
   logic             retarget;

   scs_code_enum #(.NFRAC(NFRAC)) i_enum (
      .cand_i   (cand),
      .target_i (cur_num),
      .match_o  (match)
   );

   scs_code_store #(.W(CW), .DEPTH(LIST_DEPTH)) i_store (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clr_i       (store_clr),
      .push_i      (store_push),
      .push_word_i (cand),
      .rd_idx_i    (idx),
      .rd_word_o   (rd_word),
      .count_o     (count)
   );

   assign at_last    = (CNTW'(idx) == count - CNTW'(1));
   assign retarget   = (state == ST_RUN) && tick_i && at_last && (num_i != cur_num);
   assign store_clr  = ((state == ST_IDLE) && start_i) || retarget;
   assign store_push = (state == ST_BUILD) && match;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state   <= ST_IDLE;
         cand    <= '0;
         idx     <= '0;
         cur_num <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start_i) begin
                  state   <= ST_BUILD;
                  cand    <= '0;
                  cur_num <= num_i;
               end
            end
            ST_BUILD: begin
               cand <= cand + CW'(1);
               if (cand == CAND_LAST) begin
                  state <= ST_RUN;
                  idx   <= '0;
               end
            end
            ST_RUN: begin
               if (tick_i) begin
                  if (retarget) begin
                     state   <= ST_BUILD;
                     cand    <= '0;
                     cur_num <= num_i;
                  end else if (at_last) begin
                     idx <= '0;
                  end else begin
                     idx <= idx + IW'(1);
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign active_o = (state == ST_RUN);
   assign code_o   = active_o ? rd_word : '0;

   scs_cap_decode #(.NFRAC(NFRAC)) i_decode (
      .code_i    (code_o),
      .src_en_o  (src_en_o),
      .cap_cmd_o (cap_cmd_o)
   );

   // R1
   value_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      active_o |-> (scs_pkg::code_value(32'(code_o), NFRAC) == int'(cur_num)));

   // R4
   hold_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_o && !tick_i) |=> (active_o && $stable(code_o)));

   // R8
   midcycle_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_o && tick_i && !at_last) |=> (active_o && $stable(cur_num)));

   // R9
   start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_o && start_i && !tick_i) |=> $stable(cur_num));

endmodule

// File: tb/test_scs_phase_seq.sv
module test_scs_phase_seq;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [7:0] code;
      int         k;
      string      req;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] num = '0;
   logic       start = 1'b0;
   logic       tick = 1'b0;
   logic       active;
   logic [7:0] code;
   logic       src_en;
   logic [5:0] cap_cmd;

   exp_t       sb_q[$];
   logic [7:0] seen_q[$];
   logic [7:0] cur_list[$];
   int         cur_idx = 0;
   int         cur_k = 0;
   int         checks = 0;
   int         fails = 0;
   bit         done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   scs_phase_seq i_scs_phase_seq (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .num_i     (num),
      .start_i   (start),
      .tick_i    (tick),
      .active_o  (active),
      .code_o    (code),
      .src_en_o  (src_en),
      .cap_cmd_o (cap_cmd)
   );

   task automatic chk(bit ok, string req, string what, int act, int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   function automatic int dig(logic [1:0] d);
      if (d == 2'b01) return 1;
      if (d == 2'b11) return -1;
      return 0;
   endfunction

   function automatic logic [1:0] enc(int v);
      if (v == 1) return 2'b01;
      if (v == -1) return 2'b11;
      return 2'b00;
   endfunction

   // R2: nested loops in digit order 0,+1,-1 give ascending encodings
   function automatic void fill(int k);
      int vals[3] = '{0, 1, -1};
      cur_list.delete();
      for (int a0 = 0; a0 < 2; a0++)
         for (int i1 = 0; i1 < 3; i1++)
            for (int i2 = 0; i2 < 3; i2++)
               for (int i3 = 0; i3 < 3; i3++)
                  if (a0*8 + vals[i1]*4 + vals[i2]*2 + vals[i3] == k)
                     cur_list.push_back({enc(a0), enc(vals[i1]), enc(vals[i2]), enc(vals[i3])});
   endfunction

   function automatic void push_exp(string req);
      exp_t e;
      e.code = cur_list[cur_idx];
      e.k    = cur_k;
      e.req  = req;
      sb_q.push_back(e);
   endfunction

   // monitor: pops one expected item per falling edge
   always @(negedge clk) begin
      if (sb_q.size() != 0) begin
         exp_t e;
         int   v;
         e = sb_q.pop_front();
         seen_q.push_back(code);
         chk(active == 1'b1, e.req, "active", int'(active), 1);
         chk(code == e.code, e.req, "code", int'(code), int'(e.code));
         v = dig(code[7:6])*8 + dig(code[5:4])*4 + dig(code[3:2])*2 + dig(code[1:0]);
         chk(v == e.k, "R1", "code value", v, e.k);
         chk(src_en == (e.code[7:6] == 2'b01), "R5", "src_en", int'(src_en),
             int'(e.code[7:6] == 2'b01));
         for (int j = 1; j <= 3; j++) begin
            logic [1:0] d;
            logic [1:0] ec;
            d  = e.code[2*(3-j) +: 2];
            ec = (d == 2'b11) ? 2'b01 : (d == 2'b01) ? 2'b10 : 2'b00;
            chk(cap_cmd[2*(j-1) +: 2] == ec, "R6", "cap_cmd", int'(cap_cmd[2*(j-1) +: 2]), int'(ec));
         end
      end
   end

   // R3 R8: outputs idle for 255 edges, first code at the 256th
   task automatic wait_build(int k);
      repeat (255) @(posedge clk);
      @(negedge clk);
      chk(!active, "R3", "active during build", int'(active), 0);
      chk(code == 8'h00 && cap_cmd == 6'h00 && !src_en, "R8", "idle outputs during build",
          int'(code), 0);
      @(posedge clk);
      #1;
      fill(k);
      cur_k   = k;
      cur_idx = 0;
      seen_q.delete();
      push_exp("R3");
   endtask

   task automatic do_start(int k);
      @(posedge clk); #1;
      num   = 3'(k);
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      wait_build(k);
   endtask

   // returns 1 when the tick caused a rebuild
   task automatic tick_once(output bit rebuilt);
      @(posedge clk); #1;
      tick = 1'b1;
      @(posedge clk); #1;
      tick = 1'b0;
      rebuilt = 1'b0;
      if (cur_idx == cur_list.size() - 1 && int'(num) != cur_k) begin
         rebuilt = 1'b1;
         wait_build(int'(num));
      end else begin
         cur_idx = (cur_idx + 1) % cur_list.size();
         push_exp("R2,R4");
      end
   endtask

   task automatic steps(int n);
      bit rb;
      for (int s = 0; s < n; s++) tick_once(rb);
   endtask

   task automatic run_to_rebuild(int k_new);
      bit rb;
      int guard;
      num   = 3'(k_new);
      guard = 0;
      rb    = 1'b0;
      while (!rb && guard < 20) begin
         tick_once(rb);
         guard++;
      end
      chk(rb, "R8", "rebuild after cycle end", int'(rb), 1);
   endtask

   // R7: count and charge/discharge balance over one observed cycle
   task automatic balance_check();
      @(negedge clk); #1;
      chk(seen_q.size() >= 4, "R7", "codes per cycle", seen_q.size(), 4);
      for (int j = 0; j < 3; j++) begin
         bit has_pos;
         bit has_neg;
         has_pos = 1'b0;
         has_neg = 1'b0;
         foreach (seen_q[i]) begin
            if (seen_q[i][2*j +: 2] == 2'b01) has_pos = 1'b1;
            if (seen_q[i][2*j +: 2] == 2'b11) has_neg = 1'b1;
         end
         chk(!has_pos || has_neg, "R7", "discharge for charged capacitor", int'(has_neg), 1);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      bit rb;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R9 reset state
      chk(!active && code == 8'h00 && !src_en && cap_cmd == 6'h00, "R9", "reset outputs",
          int'(code), 0);
      rst_n = 1'b1;
      // R9 tick before start ignored
      @(posedge clk); #1; tick = 1'b1;
      @(posedge clk); #1; tick = 1'b0;
      @(negedge clk);
      chk(!active, "R9", "tick while idle", int'(active), 0);

      // 3/8: five codes 05,13,1D,73,7D
      do_start(3);
      chk(cur_list.size() == 5, "R2", "list size for 3", cur_list.size(), 5);
      steps(4);
      balance_check();
      steps(8);
      // R4 hold without tick
      repeat (4) @(posedge clk);
      #1;
      push_exp("R4");
      // R9 start while active ignored
      @(posedge clk); #1; num = 3'd3; start = 1'b1;
      @(posedge clk); #1; start = 1'b0;
      push_exp("R9");

      // R8 change mid-cycle: old list finishes first
      run_to_rebuild(5);
      steps(4);
      balance_check();
      steps(3);

      run_to_rebuild(7);
      steps(3);
      balance_check();

      // R10 numerator zero: single all-zero code
      run_to_rebuild(0);
      chk(cur_list.size() == 1, "R10", "list size for 0", cur_list.size(), 1);
      steps(2);

      run_to_rebuild(6);
      steps(4);

      // unchanged numerator wraps without a gap
      run_to_rebuild(1);
      steps(4);
      balance_check();
      tick_once(rb);
      chk(!rb, "R8", "wrap without rebuild", int'(rb), 0);

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule